// File: doc/BRIEF.md
# Conflict-Free Bank Write Address Generator

This block turns the running index of a coded bit into the place where that bit is stored in a 32-bank interleaver memory. The index covers three equal streams laid end to end, each of length K. The block returns a bank (column) number from 0 to 31 and an address inside that bank. Banks are not filled in natural column order. Each bit's permuted column is multiplied by an odd skew, the row is added, and the sum is reduced modulo 32. As a result, the 32 bits of any one row land in 32 different banks. Eight read lanes working in parallel on the interleaved order can then reach the banks without colliding.

The skew is the row count R when R is odd, and R + 1 when R is even, so it is always odd. The column permutation is the 5-bit bit reversal of the index modulo 32. When the parity stream is selected, one extra step of rotation is added. Indices enter on a valid/ready stream and leave on a valid/ready stream through one register stage. The upstream may present a new index only when `in_ready` is high. The downstream may hold `out_ready` low for any number of cycles, and the result then waits unchanged. K, R and the stream select are control inputs. K and R must stay constant while indices are in flight.

Top module: `rmw_wr_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The stream-local index t is `in_idx` when `in_idx` < K, `in_idx` − K when K ≤ `in_idx` < 2K, and `in_idx` − 2K when 2K ≤ `in_idx` < 3K.
- R3: `wr_row` equals floor(t / 32).
- R4: The skew S is R when R is odd (bit 0 of `n_rows` is 1) and R + 1 when R is even.
- R5: With `sel_c` = 0, `wr_col` = (rev5(t mod 32) · S + floor(t/32)) mod 32. Here rev5 reverses the five bits, so bit 0 moves to bit 4.
- R6: With `sel_c` = 1, `wr_col` is the R5 value plus 1, modulo 32.
- R7: An index accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` = 1 after that same edge, so the latency is one cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and at the next edge `out_valid`, `wr_col` and `wr_row` are unchanged.
- R9: If no index is accepted and the held result is taken or absent, `out_valid` is 0 after the edge.
- R10: For a fixed K and R, the 32 indices of one row with `sel_c` = 0 produce 32 distinct `wr_col` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_len | input | K_W | Stream length K |
| n_rows | input | R_W | Row count R of the interleaver matrix |
| sel_c | input | 1 | Adds the parity-stream rotation of one step |
| in_valid | input | 1 | An index is offered |
| in_ready | output | 1 | The stage can take an index |
| in_idx | input | IDX_W | Index into the three concatenated streams |
| out_valid | output | 1 | A bank/address pair is held |
| out_ready | input | 1 | Downstream takes the pair |
| wr_col | output | 5 | Bank number 0..31 |
| wr_row | output | K_W-5 | Address inside the bank |

## Verification
The stream length is varied between an even row count (K = 128, R = 4), odd row counts (K = 96, R = 3 and K = 200, R = 7) and a short, partly filled matrix (K = 40, R = 2). This separates a correct parity skew from one that is always or never incremented. Every index of all three streams is swept, with `sel_c` raised on the third stream. This tells apart the three range subtractions and the extra rotation. Two known placements for K = 128 are checked: element 22 goes to bank 1 at address 0, and element 57 goes to bank 0 at address 1. Random gaps in `in_valid` and random stalls on `out_ready` test holding and ordering. A full row is also checked for 32 distinct banks.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int COL_W = 5;
  localparam int N_COL = 1 << COL_W;
  typedef logic [COL_W-1:0] col_t;
endpackage

// File: rtl/rmw_local_idx.sv
module rmw_local_idx #(
  parameter int IDX_W = 15,
  parameter int K_W   = 13
) (
  input  logic [IDX_W-1:0] in_idx,
  input  logic [K_W-1:0]   blk_len,
  output logic [K_W-1:0]   local_idx
);
  localparam int XW = IDX_W + 1;

  logic [XW-1:0] idx_x, len1, len2, picked;

  assign idx_x = XW'(in_idx);
  assign len1  = XW'(blk_len);
  assign len2  = len1 << 1;

  // Stream 0, 1 or 2 by range; subtract the stream base.
  always_comb begin
    if (idx_x < len1)      picked = idx_x;
    else if (idx_x < len2) picked = idx_x - len1;
    else                   picked = idx_x - len2;
  end

  assign local_idx = picked[K_W-1:0];

  logic unused_hi;
  assign unused_hi = ^picked[XW-1:K_W];
endmodule

// File: rtl/rmw_col_perm.sv
module rmw_col_perm
  import rmw_pkg::*;
(
  input  col_t nat_col,
  output col_t perm_col
);
  // Column pattern equals the bit reversal of the natural column.
  for (genvar g = 0; g < COL_W; g++) begin : g_rev
    assign perm_col[g] = nat_col[COL_W-1-g];
  end
endmodule

// File: rtl/rmw_rot.sv
module rmw_rot
  import rmw_pkg::*;
#(
  parameter int R_W   = 8,
  parameter int ROW_W = 8
) (
  input  col_t             perm_col,
  input  logic [R_W-1:0]   n_rows,
  input  logic [ROW_W-1:0] row,
  input  logic             sel_c,
  output col_t             bank
);
  localparam int SK_W = R_W + 1;
  localparam int PR_W = COL_W + SK_W;
  localparam int SM_W = ((PR_W > ROW_W) ? PR_W : ROW_W) + 2;

  logic [SK_W-1:0] skew;
  logic [PR_W-1:0] prod;
  logic [SM_W-1:0] sum;

  // Odd skew: even row counts get one extra step.
  assign skew = SK_W'(n_rows) + SK_W'(!n_rows[0]);
  assign prod = PR_W'(perm_col) * PR_W'(skew);
  assign sum  = SM_W'(prod) + SM_W'(row) + SM_W'(sel_c);
  assign bank = sum[COL_W-1:0];

  logic unused_sum;
  assign unused_sum = ^sum[SM_W-1:COL_W];
endmodule

// File: rtl/rmw_wr_addr_gen.sv
module rmw_wr_addr_gen
  import rmw_pkg::*;
#(
  parameter int IDX_W = 15,
  parameter int K_W   = 13,
  parameter int R_W   = 8,
  localparam int ROW_W = K_W - COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K_W-1:0]   blk_len,
  input  logic [R_W-1:0]   n_rows,
  input  logic             sel_c,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [COL_W-1:0] wr_col,
  output logic [ROW_W-1:0] wr_row
);
  logic [K_W-1:0]   t_idx;
  col_t             nat_col, perm_col, bank_d;
  logic [ROW_W-1:0] row_d;
  logic             take;

  rmw_local_idx #(.IDX_W(IDX_W), .K_W(K_W)) u_local (
    .in_idx    (in_idx),
    .blk_len   (blk_len),
    .local_idx (t_idx)
  );

  assign nat_col = t_idx[COL_W-1:0];
  assign row_d   = t_idx[K_W-1:COL_W];

  rmw_col_perm u_perm (
    .nat_col  (nat_col),
    .perm_col (perm_col)
  );

  rmw_rot #(.R_W(R_W), .ROW_W(ROW_W)) u_rot (
    .perm_col (perm_col),
    .n_rows   (n_rows),
    .row      (row_d),
    .sel_c    (sel_c),
    .bank     (bank_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_col    <= '0;
      wr_row    <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        wr_col <= bank_d;
        wr_row <= row_d;
      end
    end
  end
endmodule

// File: rtl/rmw_wr_addr_gen_chk.sv
module rmw_wr_addr_gen_chk #(
  parameter int IDX_W = 15,
  parameter int K_W   = 13,
  parameter int R_W   = 8,
  parameter int ROW_W = K_W - 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [K_W-1:0]   blk_len,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] in_idx,
  input logic             out_valid,
  input logic             out_ready,
  input logic [4:0]       wr_col,
  input logic [ROW_W-1:0] wr_row
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(wr_col) && $stable(wr_row)));

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && (!out_valid || out_ready)) |=> !out_valid);

  p_row_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ((IDX_W+1)'(in_idx) < (IDX_W+1)'(blk_len)))
      |=> (wr_row == ROW_W'($past(in_idx) >> 5)));
endmodule

bind rmw_wr_addr_gen rmw_wr_addr_gen_chk #(
  .IDX_W(IDX_W), .K_W(K_W), .R_W(R_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_len(blk_len), .in_valid(in_valid),
  .in_ready(in_ready), .in_idx(in_idx), .out_valid(out_valid),
  .out_ready(out_ready), .wr_col(wr_col), .wr_row(wr_row)
);

// File: tb/rmw_wr_addr_gen_test.sv
module rmw_wr_addr_gen_test;
  localparam int IDX_W = 15;
  localparam int K_W   = 13;
  localparam int R_W   = 8;
  localparam int ROW_W = K_W - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [K_W-1:0]   blk_len = '0;
  logic [R_W-1:0]   n_rows = '0;
  logic             sel_c = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IDX_W-1:0] in_idx = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [4:0]       wr_col;
  logic [ROW_W-1:0] wr_row;

  always #5 clk = ~clk;

  rmw_wr_addr_gen #(.IDX_W(IDX_W), .K_W(K_W), .R_W(R_W)) uut (
    .clk(clk), .rst_n(rst_n), .blk_len(blk_len), .n_rows(n_rows),
    .sel_c(sel_c), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .out_valid(out_valid), .out_ready(out_ready),
    .wr_col(wr_col), .wr_row(wr_row)
  );

  int n_checks = 0;
  int n_fails = 0;
  int cur_k, cur_r;
  int q_col[$];
  int q_row[$];
  string q_tag[$];
  bit stall_prev = 0;
  int saved_col, saved_row;
  bit last_ov;
  bit collect = 0;
  int bank_mask;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference placement computed from the requirement text.
  task automatic ref_place(input int idx, input int k, input int r, input bit c,
                           output int col, output int row, output string tag);
    int t, m, p, s;
    if (idx < k) t = idx; else if (idx < 2*k) t = idx - k; else t = idx - 2*k;
    row = t / 32;
    m = t % 32;
    p = 0;
    for (int b = 0; b < 5; b++) if (((m >> b) & 1) == 1) p += (1 << (4 - b));
    s = (r % 2 == 1) ? r : r + 1;
    col = (p * s + row + (c ? 1 : 0)) % 32;
    tag = c ? "R6" : ((t != idx) ? "R2" : "R5");
    if (r % 2 == 1) tag = {tag, " R4"};
  endtask

  task automatic cyc(input bit iv, input int idx, input bit c, input bit ordy,
                     output bit accepted);
    int ec, er;
    string tg;
    @(negedge clk);
    if (stall_prev) begin
      chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
      chk(int'(wr_col) == saved_col && int'(wr_row) == saved_row, "R8 data held",
          int'(wr_col), saved_col);
    end
    in_valid = iv; in_idx = IDX_W'(idx); sel_c = c; out_ready = ordy;
    #1;
    last_ov = out_valid;
    if (out_valid && out_ready) begin
      if (q_col.size() == 0) chk(1'b0, "R7 unexpected output", int'(wr_col), -1);
      else begin
        ec = q_col.pop_front(); er = q_row.pop_front(); tg = q_tag.pop_front();
        chk(int'(wr_col) == ec, {tg, " wr_col"}, int'(wr_col), ec);
        chk(int'(wr_row) == er, "R3 wr_row", int'(wr_row), er);
        if (collect) bank_mask |= (1 << wr_col);
      end
    end
    if (out_valid && !out_ready) chk(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
    accepted = in_valid && in_ready;
    if (accepted) begin
      ref_place(idx, cur_k, cur_r, c, ec, er, tg);
      q_col.push_back(ec); q_row.push_back(er); q_tag.push_back(tg);
    end
    stall_prev = out_valid && !out_ready;
    saved_col = int'(wr_col); saved_row = int'(wr_row);
  endtask

  task automatic set_cfg(input int k, input int r);
    cur_k = k; cur_r = r;
    blk_len = K_W'(k); n_rows = R_W'(r);
  endtask

  task automatic drain();
    bit a;
    for (int i = 0; i < 8 && q_col.size() > 0; i++) cyc(0, 0, 0, 1, a);
    chk(q_col.size() == 0, "R7 drained", q_col.size(), 0);
  endtask

  task automatic sweep(input int k, input int r);
    bit a;
    set_cfg(k, r);
    for (int idx = 0; idx < 3*k; idx++) begin
      a = 0;
      while (!a) cyc(($urandom % 4) != 0, idx, idx >= 2*k, ($urandom % 10) < 7, a);
    end
    drain();
  endtask

  initial begin
    bit a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // Known placements with K=128, R=4: element 22 -> bank 1, 57 -> bank 0 row 1.
    set_cfg(128, 4);
    cyc(1, 22, 0, 1, a);
    cyc(0, 0, 0, 1, a);
    chk(last_ov == 1'b1, "R7 one-cycle latency", int'(last_ov), 1);
    cyc(0, 0, 0, 1, a);
    chk(last_ov == 1'b0, "R9 idle drops valid", int'(last_ov), 0);
    cyc(1, 57, 0, 1, a);
    cyc(0, 0, 0, 1, a);
    drain();

    // Stall: hold output for several cycles.
    cyc(1, 130, 0, 0, a);
    cyc(1, 131, 0, 0, a);
    cyc(1, 131, 0, 0, a);
    cyc(1, 131, 0, 0, a);
    cyc(0, 0, 0, 1, a);
    drain();

    // R10: one full row lands in 32 distinct banks.
    collect = 1; bank_mask = 0;
    for (int i = 0; i < 32; i++) cyc(1, 64 + i, 0, 1, a);
    drain();
    collect = 0;
    chk(bank_mask == -1, "R10 distinct banks", bank_mask, -1);

    sweep(128, 4);
    sweep(96, 3);
    sweep(40, 2);
    sweep(200, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule